// File: doc/BRIEF.md
# HDLC Data Link Transmitter

This block serializes the transmit side of a low-rate data link channel carried inside a framer. It emits one bit each time the framer raises a channel-enable strobe and holds the bit steady between strobes. It has two modes. In message mode it builds HDLC frames: an opening flag, the payload with zero insertion, a complemented CRC-16 check sequence and a closing flag. While no frame is waiting, it fills the line with flags. In bit-oriented mode it repeats a 16-bit codeword built from a 6-bit code supplied by the host.

The host controls the block through four level inputs: mode select, idle request, abort request and abort suppression. Payload bytes come from a first-word-fall-through byte queue that has a valid flag and an end-of-frame flag. The block drains that queue with a one-cycle pop pulse. Work is done in units of one octet for flags, data bytes and abort fill, and 16 bits for the check sequence and for codewords. Mode and request changes take effect at the next unit boundary. When a frame is cut off by an abort or by a switch to bit-oriented mode, the queued bytes left in that frame are popped and thrown away.

Top module: `dl_hdlc_tx`

## Requirements
- R1: `tx_bit` changes only on the clock edge that follows a cycle with `ch_en` high, and it holds its value otherwise. After reset it is 1.
- R2: In message mode with an empty queue and no request, the output is an unbroken run of flag octets 0x7E. Every octet is sent least significant bit first.
- R3: In message mode a frame is sent as follows: an opening flag, then each queued byte least significant bit first, popped exactly once, up to and including the byte marked last, then the check sequence, then a closing flag.
- R4: Between the opening and closing flags, a 0 is inserted after every five consecutive 1 bits of payload or check sequence. This includes a run that ends at the last check bit. Flags and abort fill never get a 0 inserted.
- R5: The check sequence is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, taken over the payload bits. It is sent complemented, least significant bit first.
- R6: In message mode, while `idle_req` is 1 and no frame is in progress, only flags are sent and no byte is popped. The waiting frame starts at the first octet boundary after the request drops.
- R7: `idle_req` has no effect in bit-oriented mode.
- R8: In bit-oriented mode (`mode_msg` = 0) the output repeats a 16-bit word: eight 1s, then a 0, then `bos_code` least significant bit first, then a 0. No byte is popped.
- R9: If `mode_msg` falls while payload bytes are being sent and `abort_hold` is 0, the next unit is eight 1s, and the codewords follow it. The rest of the frame is popped from the queue and discarded.
- R10: If `abort_hold` is 1 in the same situation, the codewords start at the next octet boundary with no abort fill. The rest of the frame is still discarded.
- R11: While `abort_req` is 1, octets of eight 1s are sent in place of any other output. A frame cut off in its payload is discarded, and once the request drops the line returns to flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel-enable strobe; one output bit per high cycle |
| mode_msg | input | 1 | 1 = message (frame) mode, 0 = bit-oriented codeword mode |
| idle_req | input | 1 | Force flag fill in message mode |
| abort_req | input | 1 | Force abort fill (all ones) |
| abort_hold | input | 1 | Suppress the automatic abort on leaving message mode |
| bos_code | input | 6 | Code field of the bit-oriented word |
| fifo_data | input | 8 | Head byte of the payload queue |
| fifo_valid | input | 1 | Payload queue holds a byte |
| fifo_last | input | 1 | Head byte ends its frame |
| fifo_pop | output | 1 | Removes the head byte at this clock edge |
| tx_bit | output | 1 | Serial data link output |

## Verification
The hardest case to reach from the ports is the switch out of message mode partway through a frame, because the abort is decided only at an octet boundary that moves with zero insertion. The stimulus makes this boundary fixed. It starts each such case from reset with a first payload byte of 0x00, counts strobes, and flips `mode_msg` or `abort_req` in the middle of that byte. The abort fill and the codewords then fall on known strobe numbers. Byte counts at the queue confirm that the remaining bytes of the frame were discarded.

// File: rtl/dl_hdlc_pkg.sv
package dl_hdlc_pkg;
    localparam int DL_DW        = 8;
    localparam int DL_CODE_W    = 6;
    localparam int DL_SH_W      = 16;
    localparam int DL_CNT_W     = $clog2(DL_SH_W + 1);
    localparam int DL_RUN_W     = 3;
    localparam int DL_STUFF_RUN = 5;
    localparam logic [DL_SH_W-1:0] DL_CRC_POLY = 16'h8408;
    localparam logic [DL_SH_W-1:0] DL_CRC_INIT = 16'hFFFF;
    localparam logic [DL_DW-1:0]   DL_FLAG     = 8'h7E;
    localparam logic [DL_DW-1:0]   DL_ONES     = 8'hFF;

    typedef enum logic [2:0] {U_FLAG, U_DATA, U_FCS, U_ABORT, U_BOS} unit_e;
    typedef enum logic [1:0] {PH_IDLE, PH_DATA, PH_FCS, PH_CLOSE} phase_e;

    typedef struct packed {
        unit_e                 unit;
        phase_e                phase;
        logic [DL_SH_W-1:0]    sh;
        logic [DL_CNT_W-1:0]   left;
        logic [DL_RUN_W-1:0]   ones;
        logic [DL_SH_W-1:0]    crc;
        logic                  flush;
        logic                  tx;
    } dl_state_t;
endpackage

// File: rtl/dl_crc_bit.sv
module dl_crc_bit
    import dl_hdlc_pkg::*;
(
    input  logic [DL_SH_W-1:0] crc_in,
    input  logic               bit_in,
    output logic [DL_SH_W-1:0] crc_out
);
    logic fb;
    always_comb begin
        fb      = crc_in[0] ^ bit_in;
        crc_out = (crc_in >> 1) ^ (fb ? DL_CRC_POLY : '0);
    end
endmodule

// File: rtl/dl_bos_word.sv
module dl_bos_word
    import dl_hdlc_pkg::*;
(
    input  logic [DL_CODE_W-1:0] code,
    output logic [DL_SH_W-1:0]   word
);
    // sent LSB first: eight ones, a zero, the code, a zero
    always_comb word = {1'b0, code, 1'b0, DL_ONES};
endmodule

// File: rtl/dl_hdlc_tx.sv
module dl_hdlc_tx
    import dl_hdlc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ch_en,
    input  logic                 mode_msg,
    input  logic                 idle_req,
    input  logic                 abort_req,
    input  logic                 abort_hold,
    input  logic [DL_CODE_W-1:0] bos_code,
    input  logic [DL_DW-1:0]     fifo_data,
    input  logic                 fifo_valid,
    input  logic                 fifo_last,
    output logic                 fifo_pop,
    output logic                 tx_bit
);
    localparam logic [DL_CNT_W-1:0] OCT_LEN  = DL_CNT_W'(DL_DW);
    localparam logic [DL_CNT_W-1:0] WORD_LEN = DL_CNT_W'(DL_SH_W);
    localparam logic [DL_RUN_W-1:0] RUN_MAX  = DL_RUN_W'(DL_STUFF_RUN);

    dl_state_t q, d;

    unit_e               cur_unit;
    phase_e              cur_phase;
    logic [DL_SH_W-1:0]  cur_sh;
    logic [DL_CNT_W-1:0] cur_left;
    logic                cur_flush;
    logic                stuff, data_pop, flush_pop;
    logic [DL_SH_W-1:0]  bos_word, crc_nx;

    dl_bos_word u_bos (.code(bos_code), .word(bos_word));
    dl_crc_bit  u_crc (.crc_in(q.crc), .bit_in(cur_sh[0]), .crc_out(crc_nx));

    // unit selection at octet or word boundaries
    always_comb begin
        cur_unit  = q.unit;
        cur_phase = q.phase;
        cur_sh    = q.sh;
        cur_left  = q.left;
        cur_flush = q.flush;
        data_pop  = 1'b0;
        stuff     = ch_en && (q.ones == RUN_MAX) &&
                    (q.unit == U_DATA || q.unit == U_FCS);
        flush_pop = q.flush && fifo_valid;
        if (flush_pop && fifo_last) cur_flush = 1'b0;

        if (ch_en && !stuff && q.left == '0) begin
            cur_left = OCT_LEN;
            if (abort_req) begin
                cur_unit  = U_ABORT;
                cur_sh    = {{DL_DW{1'b0}}, DL_ONES};
                cur_flush = cur_flush || (q.phase == PH_DATA);
                cur_phase = PH_IDLE;
            end else if (!mode_msg) begin
                if (q.phase != PH_IDLE && !abort_hold) begin
                    cur_unit = U_ABORT;
                    cur_sh   = {{DL_DW{1'b0}}, DL_ONES};
                end else begin
                    cur_unit = U_BOS;
                    cur_sh   = bos_word;
                    cur_left = WORD_LEN;
                end
                cur_flush = cur_flush || (q.phase == PH_DATA);
                cur_phase = PH_IDLE;
            end else begin
                unique case (q.phase)
                    PH_IDLE: begin
                        cur_unit = U_FLAG;
                        cur_sh   = {{DL_DW{1'b0}}, DL_FLAG};
                        if (!idle_req && fifo_valid && !q.flush) cur_phase = PH_DATA;
                    end
                    PH_DATA: begin
                        if (fifo_valid) begin
                            cur_unit = U_DATA;
                            cur_sh   = {{DL_DW{1'b0}}, fifo_data};
                            data_pop = 1'b1;
                            if (fifo_last) cur_phase = PH_FCS;
                        end else begin
                            // underrun: abandon the frame
                            cur_unit  = U_ABORT;
                            cur_sh    = {{DL_DW{1'b0}}, DL_ONES};
                            cur_phase = PH_IDLE;
                        end
                    end
                    PH_FCS: begin
                        cur_unit  = U_FCS;
                        cur_sh    = ~q.crc;
                        cur_left  = WORD_LEN;
                        cur_phase = PH_CLOSE;
                    end
                    default: begin
                        cur_unit  = U_FLAG;
                        cur_sh    = {{DL_DW{1'b0}}, DL_FLAG};
                        cur_phase = PH_IDLE;
                    end
                endcase
            end
        end
    end

    // bit emission and next state
    always_comb begin
        d       = q;
        d.phase = cur_phase;
        d.flush = cur_flush;
        if (ch_en) begin
            if (stuff) begin
                d.tx   = 1'b0;
                d.ones = '0;
            end else begin
                d.tx   = cur_sh[0];
                d.sh   = cur_sh >> 1;
                d.left = cur_left - 1'b1;
                d.unit = cur_unit;
                if (cur_unit == U_DATA || cur_unit == U_FCS)
                    d.ones = cur_sh[0] ? q.ones + 1'b1 : '0;
                else
                    d.ones = '0;
                if (cur_unit == U_DATA)      d.crc = crc_nx;
                else if (cur_unit == U_FLAG) d.crc = DL_CRC_INIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.unit  <= U_FLAG;
            q.phase <= PH_IDLE;
            q.sh    <= '0;
            q.left  <= '0;
            q.ones  <= '0;
            q.crc   <= DL_CRC_INIT;
            q.flush <= 1'b0;
            q.tx    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign fifo_pop = data_pop | flush_pop;
    assign tx_bit   = q.tx;
endmodule

// File: rtl/dl_hdlc_tx_chk.sv
module dl_hdlc_tx_chk
    import dl_hdlc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ch_en,
    input logic       tx_bit,
    input logic       fifo_pop,
    input logic       fifo_valid,
    input logic [2:0] unit_st,
    input logic [1:0] phase_st,
    input logic [2:0] ones_st,
    input logic [4:0] left_st
);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> $stable(tx_bit));

    // R3
    pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_valid);

    // R11
    abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && unit_st == 3'(U_ABORT) && left_st != 5'd0) |=> tx_bit);

    // R4
    stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && ones_st == 3'd5 &&
         (unit_st == 3'(U_DATA) || unit_st == 3'(U_FCS))) |=> !tx_bit);

    // R8
    bos_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_st == 3'(U_BOS)) |-> (phase_st == 2'(PH_IDLE)));
endmodule

bind dl_hdlc_tx dl_hdlc_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_en      (ch_en),
    .tx_bit     (tx_bit),
    .fifo_pop   (fifo_pop),
    .fifo_valid (fifo_valid),
    .unit_st    (q.unit),
    .phase_st   (q.phase),
    .ones_st    (q.ones),
    .left_st    (q.left)
);

// File: tb/dl_hdlc_tx_test.sv
`timescale 1ns/1ps
module dl_hdlc_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ch_en = 1'b0;
    logic       mode_msg = 1'b1;
    logic       idle_req = 1'b0;
    logic       abort_req = 1'b0;
    logic       abort_hold = 1'b0;
    logic [5:0] bos_code = 6'd0;
    logic [7:0] fifo_data = 8'd0;
    logic       fifo_valid = 1'b0;
    logic       fifo_last = 1'b0;
    logic       fifo_pop;
    logic       tx_bit;

    dl_hdlc_tx uut (.*);

    always #4 clk = ~clk;

    int checks = 0, failures = 0, strobes = 0, pops = 0, ph = 0;
    logic prev_en = 1'b0, mon_on = 1'b0, last_seen = 1'b1, will_pop;
    logic exp_q[$];
    logic [7:0] fq_data[$];
    logic fq_last[$];
    logic [7:0] frame_q[$];
    string exp_tag = "";

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // driver/monitor step: compare, drive, clock, model queue
    task automatic tick();
        logic e;
        @(negedge clk);
        if (mon_on) begin
            if (prev_en) begin
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    chk(tx_bit === e, exp_tag, int'(tx_bit), int'(e));
                end
                last_seen = tx_bit;
            end else begin
                chk(tx_bit === last_seen, "R1 hold", int'(tx_bit), int'(last_seen));
            end
        end
        ph++;
        ch_en      = rst_n && (ph % 3 != 0);
        fifo_valid = fq_data.size() > 0;
        fifo_data  = fifo_valid ? fq_data[0] : 8'd0;
        fifo_last  = fifo_valid ? fq_last[0] : 1'b0;
        #1 will_pop = fifo_pop;
        prev_en = ch_en;
        if (ch_en) strobes++;
        @(posedge clk);
        if (will_pop && fq_data.size() > 0) begin
            void'(fq_data.pop_front());
            void'(fq_last.pop_front());
            pops++;
        end
        #1;
    endtask

    task automatic do_reset(input logic m, input logic idl, input logic hold, input logic [5:0] code);
        rst_n = 1'b0; mon_on = 1'b0; abort_req = 1'b0;
        exp_q.delete(); fq_data.delete(); fq_last.delete();
        mode_msg = m; idle_req = idl; abort_hold = hold; bos_code = code;
        repeat (3) tick();
        rst_n = 1'b1;
        prev_en = 1'b0; strobes = 0; pops = 0; last_seen = 1'b1; mon_on = 1'b1;
        chk(tx_bit === 1'b1, "R1 reset tx", int'(tx_bit), 1);
    endtask

    task automatic wait_strobes(input int n);
        while (strobes < n) tick();
    endtask

    task automatic drain();
        while (exp_q.size() > 0) tick();
    endtask

    task automatic push_raw(input logic [7:0] b);
        for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    endtask

    task automatic push_flag();
        push_raw(8'h7E);
    endtask

    task automatic push_bos(input logic [5:0] c);
        push_raw(8'hFF);
        exp_q.push_back(1'b0);
        for (int i = 0; i < 6; i++) exp_q.push_back(c[i]);
        exp_q.push_back(1'b0);
    endtask

    // load frame_q into the queue model and expect the whole frame
    task automatic push_frame();
        logic [15:0] crc = 16'hFFFF;
        logic [15:0] fcs;
        int ones = 0;
        logic b;
        push_flag();
        for (int k = 0; k < frame_q.size(); k++) begin
            fq_data.push_back(frame_q[k]);
            fq_last.push_back(k == frame_q.size() - 1);
            for (int i = 0; i < 8; i++) begin
                b = frame_q[k][i];
                crc = (crc >> 1) ^ (((crc[0] ^ b) != 1'b0) ? 16'h8408 : 16'h0000);
                exp_q.push_back(b);
                ones = b ? ones + 1 : 0;
                if (ones == 5) begin exp_q.push_back(1'b0); ones = 0; end
            end
        end
        fcs = ~crc;
        for (int i = 0; i < 16; i++) begin
            exp_q.push_back(fcs[i]);
            ones = fcs[i] ? ones + 1 : 0;
            if (ones == 5) begin exp_q.push_back(1'b0); ones = 0; end
        end
        push_flag();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // S1: idle flag fill with empty queue
        do_reset(1'b1, 1'b0, 1'b0, 6'd0);
        chk(fifo_pop === 1'b0, "R1 reset pop", int'(fifo_pop), 0);
        exp_tag = "R2 flag fill";
        repeat (3) push_flag();
        drain();
        chk(pops == 0, "R2 no pop", pops, 0);

        // S2: frame with long runs of ones
        do_reset(1'b1, 1'b0, 1'b0, 6'd0);
        exp_tag = "R3 R4 R5 frame";
        frame_q = '{8'hFF, 8'h7E, 8'h3F, 8'h01};
        push_frame();
        push_flag(); push_flag();
        drain();
        chk(pops == 4, "R3 pop count", pops, 4);

        // S3: idle request holds a waiting frame
        do_reset(1'b1, 1'b1, 1'b0, 6'd0);
        exp_tag = "R6 idle then frame";
        repeat (4) push_flag();
        frame_q = '{8'hA5, 8'h1F};
        push_frame();
        wait_strobes(30);
        chk(pops == 0, "R6 no pop while idle", pops, 0);
        idle_req = 1'b0;
        drain();
        chk(pops == 2, "R6 frame popped", pops, 2);

        // S4: bit-oriented words, idle request ignored
        do_reset(1'b0, 1'b1, 1'b0, 6'b101101);
        exp_tag = "R7 R8 codeword";
        fq_data.push_back(8'h55); fq_last.push_back(1'b1);
        repeat (3) push_bos(6'b101101);
        drain();
        chk(pops == 0, "R8 no pop in codeword mode", pops, 0);

        // S5: leave message mode mid-frame, abort fill expected
        do_reset(1'b1, 1'b0, 1'b0, 6'b010011);
        exp_tag = "R9 auto abort";
        frame_q = '{8'h00, 8'h11, 8'h22};
        for (int k = 0; k < 3; k++) begin
            fq_data.push_back(frame_q[k]); fq_last.push_back(k == 2);
        end
        push_flag(); push_raw(8'h00); push_raw(8'hFF);
        push_bos(6'b010011); push_bos(6'b010011);
        wait_strobes(12);
        mode_msg = 1'b0;
        drain();
        chk(pops == 3, "R9 frame discarded", pops, 3);

        // S6: same switch with abort suppressed
        do_reset(1'b1, 1'b0, 1'b1, 6'b110001);
        exp_tag = "R10 no abort";
        for (int k = 0; k < 3; k++) begin
            fq_data.push_back(frame_q[k]); fq_last.push_back(k == 2);
        end
        push_flag(); push_raw(8'h00);
        push_bos(6'b110001); push_bos(6'b110001);
        wait_strobes(12);
        mode_msg = 1'b0;
        drain();
        chk(pops == 3, "R10 frame discarded", pops, 3);

        // S7: host abort during payload
        do_reset(1'b1, 1'b0, 1'b0, 6'd0);
        exp_tag = "R11 host abort";
        for (int k = 0; k < 3; k++) begin
            fq_data.push_back(frame_q[k]); fq_last.push_back(k == 2);
        end
        push_flag(); push_raw(8'h00); push_raw(8'hFF); push_raw(8'hFF);
        push_flag(); push_flag();
        wait_strobes(12);
        abort_req = 1'b1;
        wait_strobes(28);
        abort_req = 1'b0;
        drain();
        chk(pops == 3, "R11 frame discarded", pops, 3);
        chk(fq_data.size() == 0, "R11 queue empty", fq_data.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule